// File: doc/BRIEF.md
# Conversion Synchronization Controller

This block supervises an active-low, dual-purpose sync/reset pin for a decimating converter. The pin is sampled on the modulator clock. Each low pulse is timed and sorted into one of three kinds: a glitch that is ignored, a synchronization request, or a device reset request. A synchronization request is judged by where its leading falling edge lands against an internal data-rate counter, which ticks once per output period (osr_i modulator clocks). The block then either leaves the conversion cadence untouched or restarts it from that edge.

When a restart happens, the block pulses a filter-reset strobe for the decimation filters and realigns its data-ready cadence to the falling edge. It also marks the next results as unsettled so that the host can discard them. In global-chop mode every synchronization request restarts, even an aligned one. A long low pulse only raises a one-cycle reset-request output. The filter arithmetic, the serial port and the modulator itself sit outside this block.

Cycle numbers below count rising edges: "cycle n" is the clock period that follows rising edge n. A pin level driven in cycle a is first sampled at edge a+1. osr_i and the threshold RST_CYC (at least 3) must stay constant outside reset.

Top module: `conv_sync_ctrl`

## Requirements
- R1: While rst_n is low, drdy_o, unsettled_o, filt_rst_o and rst_req_o are all 0.
- R2: Without any restart, drdy_o is high for one cycle in every osr_i cycles, the first time in cycle osr_i−1 after reset release (cycle 0 is the one in which rst_n rises).
- R3: The pin passes through two sampling flops. A low level that only one rising edge samples is a glitch: it produces no filt_rst_o pulse and no change in the drdy_o cadence.
- R4: A low level that W consecutive rising edges sample, with 2 ≤ W < RST_CYC, is a synchronization request. Suppose the pin is driven low in cycle a for W cycles. If the request causes a restart, filt_rst_o is high only in cycle a+W+3.
- R5: The falling edge counts as aligned when drdy_o is high in cycle a+2. An aligned request with gchop_i = 0 leaves filt_rst_o low and changes neither the drdy_o nor the unsettled_o sequence.
- R6: A misaligned request with gchop_i = 0 restarts the cadence. Up to cycle a+W+2 the old cadence continues. From cycle a+W+3 on, drdy_o is high exactly in cycles a+2+k·osr_i.
- R7: With gchop_i = 1, every synchronization request restarts as in R4 and R6, whether or not it is aligned.
- R8: A low level sampled on RST_CYC or more consecutive edges is a reset request. rst_req_o is high only in cycle a+RST_CYC+2. No filt_rst_o pulse follows on release, and the cadence is kept.
- R9: unsettled_o is high only together with drdy_o, and it is high on the first two drdy_o pulses after reset release. After a restart, the count starts again: it covers the first two drdy_o pulses from the cycle in which filt_rst_o is high. From the third pulse on, unsettled_o stays low.
- R10: At the length boundary, W = RST_CYC−1 is still a synchronization request, and W = RST_CYC is a reset request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Modulator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_n_i | input | 1 | Active-low sync/reset pin, asynchronous to clk |
| osr_i | input | OSR_W | Output period in modulator clocks (≥ 2) |
| gchop_i | input | 1 | Global-chop mode: every sync request restarts |
| drdy_o | output | 1 | One-cycle data-rate tick |
| unsettled_o | output | 1 | The result delivered with this tick is not yet settled |
| filt_rst_o | output | 1 | One-cycle decimation filter reset strobe |
| rst_req_o | output | 1 | One-cycle device reset request |

## Verification
The bench sweeps every falling-edge phase of a small output period against a set of pulse lengths, and it also hits both the aligned and the misaligned edge at a period of 1024. A design that compares the edge with the tick one cycle early or late would strobe on aligned pulses and keep the cadence on misaligned ones. A restart anchored at the release instead of the edge would shift drdy_o by the pulse length. The length boundaries get their own probes: one sample versus two, and RST_CYC−1 versus RST_CYC. These catch an off-by-one classifier that swallows short syncs or turns a reset into a sync. The unsettled flag is predicted on every tick, so a counter that is not cleared on restart, or that is cleared on an aligned pulse, shows up at once.

// File: rtl/conv_sync_pkg.sv
package conv_sync_pkg;

    typedef enum logic [1:0] {
        PK_NONE   = 2'd0,
        PK_GLITCH = 2'd1,
        PK_SYNC   = 2'd2,
        PK_RESET  = 2'd3
    } pulse_kind_e;

    // Sort a finished low pulse by its sampled length.
    function automatic pulse_kind_e classify_pulse(input int unsigned len,
                                                   input int unsigned thr);
        if (len < 2)
            return PK_GLITCH;
        else if (len >= thr)
            return PK_RESET;
        return PK_SYNC;
    endfunction

endpackage

// File: rtl/pin_sampler.sv
module pin_sampler
    import conv_sync_pkg::*;
#(
    parameter int unsigned RST_CYC = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sync_n_i,
    output logic        fall_o,
    output pulse_kind_e kind_o,
    output logic        rst_req_o
);
    localparam int unsigned LEN_W = $clog2(RST_CYC + 1);
    localparam logic [LEN_W-1:0] LEN_MAX = LEN_W'(RST_CYC);
    localparam logic [LEN_W-1:0] LEN_HIT = LEN_W'(RST_CYC - 1);

    typedef struct packed {
        logic             s1;
        logic             s2;
        logic             s3;
        logic [LEN_W-1:0] len;
        logic             rreq;
    } smp_st_t;

    smp_st_t q, d;
    logic    fall, rise;

    always_comb begin
        d    = q;
        d.s1 = sync_n_i;
        d.s2 = q.s1;
        d.s3 = q.s2;
        fall = q.s3 & ~q.s2;
        rise = ~q.s3 & q.s2;
        if (fall)
            d.len = LEN_W'(1);
        else if (!q.s2 && (q.len != LEN_MAX))
            d.len = q.len + 1'b1;
        d.rreq = !q.s2 && !fall && (q.len == LEN_HIT);
        kind_o = rise ? classify_pulse(32'(q.len), RST_CYC) : PK_NONE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q <= '{s1: 1'b1, s2: 1'b1, s3: 1'b1, len: '0, rreq: 1'b0};
        else
            q <= d;
    end

    assign fall_o    = fall;
    assign rst_req_o = q.rreq;

    // R8
    rreq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req_o |=> !rst_req_o);

endmodule

// File: rtl/rate_timer.sv
module rate_timer #(
    parameter int unsigned OSR_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [OSR_W-1:0] osr_i,
    input  logic             fall_i,
    input  logic             load_i,
    output logic             drdy_o,
    output logic             aligned_o
);
    typedef struct packed {
        logic [OSR_W-1:0] ph;
        logic [OSR_W-1:0] cand;
        logic             algn;
    } tmr_st_t;

    tmr_st_t          q, d;
    logic [OSR_W-1:0] osr_m1;
    logic [OSR_W-1:0] ph_nx, cand_nx;
    logic             tick;

    always_comb begin
        d       = q;
        osr_m1  = osr_i - 1'b1;
        tick    = (q.ph >= osr_m1);
        ph_nx   = tick ? '0 : q.ph + 1'b1;
        // candidate phase: counts as if the last falling edge were a tick
        if (fall_i)
            cand_nx = '0;
        else if (q.cand >= osr_m1)
            cand_nx = '0;
        else
            cand_nx = q.cand + 1'b1;
        d.cand  = cand_nx;
        d.ph    = load_i ? cand_nx : ph_nx;
        if (fall_i)
            d.algn = tick;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q <= '{ph: '0, cand: '0, algn: 1'b0};
        else
            q <= d;
    end

    assign drdy_o    = tick;
    assign aligned_o = q.algn;

    // R2
    drdy_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (drdy_o && !load_i && (osr_i > 1)) |=> !drdy_o);

endmodule

// File: rtl/settle_track.sv
module settle_track #(
    parameter int unsigned SETTLE_N = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic drdy_i,
    input  logic restart_i,
    output logic unsettled_o
);
    localparam int unsigned CNT_W = $clog2(SETTLE_N + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(SETTLE_N);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } stl_st_t;

    stl_st_t q, d;

    always_comb begin
        d = q;
        if (restart_i)
            d.cnt = '0;
        else if (drdy_i && (q.cnt != CNT_MAX))
            d.cnt = q.cnt + 1'b1;
        unsettled_o = drdy_i && (q.cnt < CNT_MAX);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q <= '{cnt: '0};
        else
            q <= d;
    end

endmodule

// File: rtl/conv_sync_ctrl.sv
module conv_sync_ctrl
    import conv_sync_pkg::*;
#(
    parameter int unsigned OSR_W    = 11,
    parameter int unsigned RST_CYC  = 32,
    parameter int unsigned SETTLE_N = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sync_n_i,
    input  logic [OSR_W-1:0] osr_i,
    input  logic             gchop_i,
    output logic             drdy_o,
    output logic             unsettled_o,
    output logic             filt_rst_o,
    output logic             rst_req_o
);
    typedef struct packed {
        logic frst;
    } top_st_t;

    top_st_t     q, d;
    logic        fall, aligned, restart;
    pulse_kind_e kind;

    pin_sampler #(.RST_CYC(RST_CYC)) u_pin (
        .clk       (clk),
        .rst_n     (rst_n),
        .sync_n_i  (sync_n_i),
        .fall_o    (fall),
        .kind_o    (kind),
        .rst_req_o (rst_req_o)
    );

    rate_timer #(.OSR_W(OSR_W)) u_tmr (
        .clk       (clk),
        .rst_n     (rst_n),
        .osr_i     (osr_i),
        .fall_i    (fall),
        .load_i    (restart),
        .drdy_o    (drdy_o),
        .aligned_o (aligned)
    );

    settle_track #(.SETTLE_N(SETTLE_N)) u_stl (
        .clk         (clk),
        .rst_n       (rst_n),
        .drdy_i      (drdy_o),
        .restart_i   (restart),
        .unsettled_o (unsettled_o)
    );

    always_comb begin
        d       = q;
        restart = (kind == PK_SYNC) && (gchop_i || !aligned);
        d.frst  = restart;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q <= '{frst: 1'b0};
        else
            q <= d;
    end

    assign filt_rst_o = q.frst;

    // R4
    frst_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        filt_rst_o |=> !filt_rst_o);

    // R8
    no_strobe_clash_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(filt_rst_o && rst_req_o));

    // R9
    uns_needs_drdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        unsettled_o |-> drdy_o);

endmodule

// File: tb/test_conv_sync_ctrl.sv
`timescale 1ns/1ps
module test_conv_sync_ctrl;
    localparam int RST = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sync_n = 1'b1;
    logic        gchop = 1'b0;
    logic [10:0] osr_v = 11'd8;
    logic        drdy, uns, frst, rreq;

    int checks = 0, fails = 0;
    int n;
    int osr = 8, base = 0, new_base = 0;
    int acc_at = -100, frst_at = -100, rst_at = -100;
    int ecnt = 0, frst_seen = 0, rreq_seen = 0;
    bit mon_on = 0, done = 0;

    conv_sync_ctrl #(.OSR_W(11), .RST_CYC(RST), .SETTLE_N(2)) i_conv_sync_ctrl (
        .clk(clk), .rst_n(rst_n), .sync_n_i(sync_n), .osr_i(osr_v),
        .gchop_i(gchop), .drdy_o(drdy), .unsettled_o(uns),
        .filt_rst_o(frst), .rst_req_o(rreq)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk or negedge rst_n)
        if (!rst_n) n <= 0;
        else        n <= n + 1;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d (cycle %0d)", tag, act, exp, n);
        end
    endtask

    // per-cycle model of the output timing
    always @(negedge clk) begin
        if (mon_on) begin
            bit ed, eu;
            if (n == acc_at + 1) base = new_base;
            ed = ((n - base) % osr) == osr - 1;
            eu = ed && (ecnt < 2);
            chk((base == 0) ? "R2" : "R6", int'(drdy), int'(ed));
            chk("R4", int'(frst), int'(n == frst_at));
            chk("R8", int'(rreq), int'(n == rst_at));
            chk("R9", int'(uns), int'(eu));
            if (n == acc_at) ecnt = 0;
            else if (ed && ecnt < 2) ecnt++;
            if (frst) frst_seen++;
            if (rreq) rreq_seen++;
        end
    end

    task automatic do_reset(input int o, input bit gc);
        @(negedge clk);
        mon_on = 0;
        rst_n  = 1'b0;
        osr    = o;
        osr_v  = 11'(o);
        gchop  = gc;
        sync_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1", int'(drdy), 0);
        chk("R1", int'(uns), 0);
        chk("R1", int'(frst), 0);
        chk("R1", int'(rreq), 0);
        base = 0; acc_at = -100; frst_at = -100; rst_at = -100; ecnt = 0;
        rst_n  = 1'b1;
        mon_on = 1;
    endtask

    // drive a low pulse of w cycles whose edge-check cycle has phase off
    task automatic pulse(input int off, input int w, input string tag);
        int a, f0, r0;
        bit al, rs;
        @(negedge clk);
        while (((n + 2 - base) % osr) != off) @(negedge clk);
        a      = n;
        sync_n = 1'b0;
        al     = ((a + 2 - base) % osr) == osr - 1;
        rs     = (w >= 2) && (w < RST) && (gchop || !al);
        if (rs) begin
            acc_at   = a + w + 2;
            new_base = a + 3;
            frst_at  = a + w + 3;
        end
        if (w >= RST) rst_at = a + RST + 2;
        f0 = frst_seen;
        r0 = rreq_seen;
        repeat (w) @(negedge clk);
        sync_n = 1'b1;
        repeat (6) @(negedge clk);
        chk(tag, frst_seen - f0, rs ? 1 : 0);
        if (w >= RST) chk("R8", rreq_seen - r0, 1);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        int wl[5] = '{1, 2, 3, 5, 9};
        // large period: aligned, misaligned, global chop
        do_reset(1024, 1'b0);
        repeat (3200) @(negedge clk);
        pulse(1023, 4, "R5");
        repeat (200) @(negedge clk);
        pulse(100, 4, "R6");
        repeat (3200) @(negedge clk);
        gchop = 1'b1;
        pulse(1023, 4, "R7");
        repeat (2200) @(negedge clk);

        // small period: sweep every phase against several lengths
        do_reset(8, 1'b0);
        repeat (30) @(negedge clk);
        for (int off = 0; off < 8; off++) begin
            for (int k = 0; k < 5; k++) begin
                pulse(off, wl[k], (wl[k] == 1) ? "R3" : ((off == 7) ? "R5" : "R6"));
                repeat (30) @(negedge clk);
            end
        end
        pulse(3, RST - 1, "R10");
        repeat (30) @(negedge clk);
        pulse(3, RST, "R10");
        repeat (30) @(negedge clk);
        pulse(5, RST + 8, "R8");
        repeat (30) @(negedge clk);
        gchop = 1'b1;
        for (int off = 0; off < 8; off++) begin
            pulse(off, 2, "R7");
            repeat (30) @(negedge clk);
        end
        pulse(7, 1, "R3");
        repeat (40) @(negedge clk);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule